// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block drives a synchronous burst read out of a word-organised array. The host presents a start word address together with an address strobe for one cycle. After a programmable first-access latency, the block delivers one word per clock. Each word comes with its address and a valid flag. A configuration register sets the burst length to 4, 8 or 16 words or to an endless run. It also selects whether a fixed-length burst stays inside its aligned block or runs on past it.

When a burst that does not wrap leaves a 16-word row for the first time, the array needs extra time if the burst began off a four-word boundary. The block covers that delay by raising a wait flag for as many cycles as the start address's offset within its four-word group. It does this once per burst. A small on-chip word array, loaded through a simple write port, stands in for the storage.

Dropping chip enable ends any burst. A new address strobe restarts the sequence from the new address.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset, `rd_valid` and `rd_wait` are 0 and `cfg_rdata` reads 9'h06F (length code 3'b111, no-wrap 1, latency 3).
- R2: The config word puts the length code in bits [2:0], the no-wrap flag in bit 3 and the latency in bits [7:5]. Bits 4 and 8 are reserved: writes to them are ignored and they read back 0.
- R3: Take the rising edge that samples `ce` and `adv` both high as edge 0. The first word is valid after rising edge L, where L is the latency field (2..7). Codes 0 and 1 act as 2.
- R4: While `rd_valid` is high, `rd_data` equals the array word at `rd_addr`, and successive words appear on successive clocks.
- R5: With no-wrap 0 and a fixed length N, the addresses stay in the N-aligned block that holds the start address and roll over to its first word.
- R6: With no-wrap 1 and a fixed length N, the addresses run linearly from the start address. Exactly N words are delivered, after which `rd_valid` stays 0.
- R7: Length code 3'b001 gives 4 words, 3'b010 gives 8, 3'b011 gives 16 and 3'b111 gives an endless burst. Any other code also gives an endless burst, which never wraps whatever the no-wrap flag says.
- R8: In a non-wrapping burst whose start address has low two bits k ≠ 0, `rd_wait` is high and `rd_valid` low for exactly k cycles just before the first word after the start whose address has low four bits 0. That word follows at once.
- R9: A burst raises `rd_wait` at most once. A start with k = 0 raises it never, and an endless burst runs across 64-word bank boundaries without a gap.
- R10: A wrapping burst never raises `rd_wait`.
- R11: After a rising edge at which `ce` is low, `rd_valid` and `rd_wait` are 0, and they stay 0 until a new address strobe starts a burst.
- R12: An address strobe during a burst abandons it and starts a new one from the new address with the current configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable, active high |
| adv | input | 1 | Address strobe, latches `addr_in` when `ce` is high |
| addr_in | input | AW | Start word address |
| cfg_we | input | 1 | Config register write strobe |
| cfg_wdata | input | 9 | Config write value |
| cfg_rdata | output | 9 | Config register readback |
| mem_we | input | 1 | Array load strobe |
| mem_waddr | input | AW | Array load address |
| mem_wdata | input | DW | Array load data |
| rd_data | output | DW | Burst read data |
| rd_addr | output | AW | Address of the word on `rd_data` |
| rd_valid | output | 1 | `rd_data` holds a burst word |
| rd_wait | output | 1 | Array delay in progress, no data this cycle |

## Verification
Suppose the row-crossing flag or the wait counter goes wrong. Then the boundary cycle shows the wrong number of wait cycles, or a second wait burst 16 words later. The next sample of `rd_wait` at that point exposes it. A fault in the latency counter shifts the first `rd_valid` by whole cycles, which a per-cycle comparison against the expected trace catches on the first word. A wrong remaining-word count or wrap mask shows as an address outside the aligned block or as an extra or missing word, and this appears within one burst length.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int CFG_W   = 9;
  localparam int LEN_LSB = 0;
  localparam int NW_BIT  = 3;
  localparam int LAT_LSB = 5;
  localparam logic [CFG_W-1:0] CFG_RST  = 9'h06F;
  localparam logic [CFG_W-1:0] CFG_RESV = 9'h110;

  typedef enum logic [1:0] {PH_IDLE, PH_LAT, PH_DATA, PH_WAIT} phase_t;

  typedef struct packed {
    logic       cont;
    logic [4:0] words;
    logic [3:0] mask;
  } len_t;

  function automatic len_t decode_len(input logic [2:0] code);
    len_t r;
    case (code)
      3'b001:  r = '{cont: 1'b0, words: 5'd4,  mask: 4'd3};
      3'b010:  r = '{cont: 1'b0, words: 5'd8,  mask: 4'd7};
      3'b011:  r = '{cont: 1'b0, words: 5'd16, mask: 4'd15};
      default: r = '{cont: 1'b1, words: 5'd0,  mask: 4'd15};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bseq_cfg.sv
module bseq_cfg
  import bseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic [2:0]       len_code,
  output logic             nowrap,
  output logic [2:0]       lat_eff
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= CFG_RST;
    else if (we) cfg_q <= wdata & ~CFG_RESV;
  end

  logic [2:0] lat_raw;
  assign lat_raw  = cfg_q[LAT_LSB +: 3];
  assign rdata    = cfg_q;
  assign len_code = cfg_q[LEN_LSB +: 3];
  assign nowrap   = cfg_q[NW_BIT];
  assign lat_eff  = (lat_raw < 3'd2) ? 3'd2 : lat_raw;
endmodule

// File: rtl/bseq_next_addr.sv
module bseq_next_addr #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] cur,
  input  logic          wrap_en,
  input  logic [3:0]    mask,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] inc;
  assign inc = cur + 1'b1;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    if (i < 4) begin : g_low
      assign nxt[i] = (wrap_en && !mask[i]) ? cur[i] : inc[i];
    end else begin : g_high
      assign nxt[i] = wrap_en ? cur[i] : inc[i];
    end
  end
endmodule

// File: rtl/bseq_word_ram.sv
module bseq_word_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import bseq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             adv,
  input  logic [AW-1:0]    addr_in,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             mem_we,
  input  logic [AW-1:0]    mem_waddr,
  input  logic [DW-1:0]    mem_wdata,
  output logic [DW-1:0]    rd_data,
  output logic [AW-1:0]    rd_addr,
  output logic             rd_valid,
  output logic             rd_wait
);
  logic [2:0] len_code, lat_eff;
  logic       nowrap;

  bseq_cfg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .len_code(len_code), .nowrap(nowrap), .lat_eff(lat_eff)
  );

  phase_t     ph;
  logic [2:0] lat_cnt;
  logic [AW-1:0] ptr, ptr_nxt;
  logic [4:0] left;
  logic       cont, wrap_m, crossed;
  logic [3:0] mask;
  logic [1:0] off, wcnt;
  len_t       dec;

  assign dec = decode_len(len_code);

  bseq_next_addr #(.AW(AW)) u_nxt (
    .cur(ptr), .wrap_en(wrap_m), .mask(mask), .nxt(ptr_nxt)
  );

  logic latch, emit, enter_wait, need_wait;
  assign latch     = ce && adv;
  assign need_wait = !wrap_m && !crossed && (off != 2'd0) && (ptr[3:0] == 4'd0);

  always_comb begin
    emit       = 1'b0;
    enter_wait = 1'b0;
    if (ce && !adv) begin
      case (ph)
        PH_LAT:  emit = (lat_cnt == 3'd1);
        PH_DATA: if (cont || left != 5'd0) begin
                   if (need_wait) enter_wait = 1'b1;
                   else           emit       = 1'b1;
                 end
        PH_WAIT: emit = (wcnt == 2'd1);
        default: ;
      endcase
    end
  end

  bseq_word_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(emit), .raddr(ptr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; lat_cnt <= '0; ptr <= '0; left <= '0;
      cont <= 1'b0; wrap_m <= 1'b0; crossed <= 1'b0; mask <= '0;
      off <= '0; wcnt <= '0;
      rd_valid <= 1'b0; rd_wait <= 1'b0; rd_addr <= '0;
    end else if (!ce) begin
      ph <= PH_IDLE; rd_valid <= 1'b0; rd_wait <= 1'b0;
    end else if (latch) begin
      ph       <= PH_LAT;
      lat_cnt  <= lat_eff;
      ptr      <= addr_in;
      off      <= addr_in[1:0];
      left     <= dec.words;
      cont     <= dec.cont;
      mask     <= dec.mask;
      wrap_m   <= !dec.cont && !nowrap;
      crossed  <= 1'b0;
      rd_valid <= 1'b0;
      rd_wait  <= 1'b0;
    end else begin
      if (ph == PH_LAT && !emit) lat_cnt <= lat_cnt - 3'd1;
      if (emit) begin
        ph       <= PH_DATA;
        rd_valid <= 1'b1;
        rd_wait  <= 1'b0;
        rd_addr  <= ptr;
        ptr      <= ptr_nxt;
        left     <= left - 5'd1;
      end else if (enter_wait) begin
        ph       <= PH_WAIT;
        rd_valid <= 1'b0;
        rd_wait  <= 1'b1;
        wcnt     <= off;
        crossed  <= 1'b1;
      end else if (ph == PH_WAIT) begin
        wcnt <= wcnt - 2'd1;
      end else if (ph == PH_DATA) begin
        ph       <= PH_IDLE;
        rd_valid <= 1'b0;
      end
    end
  end

  // R8: a wait cycle never carries data
  p_wait_excl_r8: assert property (@(posedge clk) disable iff (rst)
    rd_wait |-> !rd_valid);

  // R11: chip enable low silences the outputs at the next edge
  p_ce_off_r11: assert property (@(posedge clk) disable iff (rst)
    !ce |=> (!rd_valid && !rd_wait));

  // R10: wrapping bursts never wait
  p_wrap_nowait_r10: assert property (@(posedge clk) disable iff (rst)
    rd_wait |-> !wrap_m);

  // R6: back-to-back words of a linear burst step by one
  p_linear_step_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_valid) && !wrap_m) |-> (rd_addr == $past(rd_addr) + 1'b1));

  // R5: back-to-back words of a wrapping burst stay in one 16-word row
  p_wrap_row_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_valid) && wrap_m) |-> (rd_addr[AW-1:4] == $past(rd_addr[AW-1:4])));
endmodule

// File: tb/burst_rd_seq_tb.sv
module burst_rd_seq_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int TMAX = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, adv = 1'b0, cfg_we = 1'b0, mem_we = 1'b0;
  logic [AW-1:0] addr_in = '0, mem_waddr = '0, rd_addr;
  logic [8:0] cfg_wdata = '0, cfg_rdata;
  logic [DW-1:0] mem_wdata = '0, rd_data;
  logic rd_valid, rd_wait;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  burst_rd_seq #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .adv(adv), .addr_in(addr_in),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .rd_data(rd_data), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_wait(rd_wait)
  );

  function automatic logic [DW-1:0] word_of(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {b ^ 8'hC3, ~b};
  endfunction

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [8:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic latch_at(input int s);
    ce = 1'b1; adv = 1'b1; addr_in = AW'(s);
    @(negedge clk);
    adv = 1'b0;
  endtask

  // Latch a burst, then compare T cycles against the trace built from the requirements
  task automatic run_burst(input int s, input int lc, input bit nw, input int lat,
                           input int T, input string req);
    bit ev[TMAX]; bit ew[TMAX]; int ea[TMAX];
    int L, N, mask, off, t, k, a;
    bit fixed, wrapm, waited;
    for (int i = 0; i < TMAX; i++) begin ev[i] = 0; ew[i] = 0; ea[i] = 0; end
    cfg_write({1'b0, 3'(lat), 1'b0, nw, 3'(lc)});
    L = (lat < 2) ? 2 : lat;
    fixed = (lc >= 1 && lc <= 3);
    N = fixed ? (4 << (lc - 1)) : 0;
    mask = fixed ? N - 1 : 15;
    wrapm = fixed && !nw;
    off = s % 4;
    t = L; k = 0; waited = 0;
    while (t <= T) begin
      if (fixed && k == N) break;
      a = wrapm ? ((s & ~mask) | ((s + k) & mask)) : ((s + k) % 256);
      if (k > 0 && !wrapm && (a % 16) == 0 && !waited && off > 0) begin
        for (int j = 0; j < off; j++) begin
          if (t <= T) ew[t] = 1;
          t++;
        end
        waited = 1;
      end
      if (t <= T) begin ev[t] = 1; ea[t] = a; end
      t++; k++;
    end
    latch_at(s);
    for (int c = 1; c <= T; c++) begin
      @(negedge clk);
      if (ev[c])
        chk(rd_valid && !rd_wait && rd_addr == AW'(ea[c]) && rd_data == word_of(ea[c]), req,
            $sformatf("c%0d v%0b w%0b a%0d d%h", c, rd_valid, rd_wait, rd_addr, rd_data),
            $sformatf("v1 w0 a%0d d%h", ea[c], word_of(ea[c])));
      else
        chk(rd_valid == 1'b0 && rd_wait == ew[c], req,
            $sformatf("c%0d v%0b w%0b", c, rd_valid, rd_wait),
            $sformatf("v0 w%0b", ew[c]));
    end
  endtask

  task automatic t_reset();
    chk(!rd_valid && !rd_wait, "R1", $sformatf("v%0b w%0b", rd_valid, rd_wait), "v0 w0");
    chk(cfg_rdata == 9'h06F, "R1", $sformatf("%h", cfg_rdata), "06f");
  endtask

  task automatic t_reserved_r2();
    cfg_write(9'h1FF);
    chk(cfg_rdata == 9'h0EF, "R2", $sformatf("%h", cfg_rdata), "0ef");
    cfg_write(9'h110);
    chk(cfg_rdata == 9'h000, "R2", $sformatf("%h", cfg_rdata), "000");
  endtask

  task automatic t_ce_drop_r11();
    run_burst(0, 7, 1'b1, 2, 5, "R11");
    ce = 1'b0;
    @(negedge clk);
    chk(!rd_valid && !rd_wait, "R11", $sformatf("v%0b w%0b", rd_valid, rd_wait), "v0 w0");
    ce = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!rd_valid && !rd_wait, "R11", $sformatf("v%0b w%0b", rd_valid, rd_wait), "v0 w0");
    end
    // drop enable inside a wait window: start 2 waits at cycles 16 and 17
    run_burst(2, 7, 1'b1, 2, 16, "R11");
    ce = 1'b0;
    @(negedge clk);
    chk(!rd_valid && !rd_wait, "R11", $sformatf("v%0b w%0b", rd_valid, rd_wait), "v0 w0");
    ce = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      mem_we = 1'b1; mem_waddr = AW'(i); mem_wdata = word_of(i);
      @(negedge clk);
    end
    mem_we = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reserved_r2();
    run_burst(6, 1, 1'b0, 2, 10, "R3 R4 R5");       // 6,7,4,5
    run_burst(13, 2, 1'b0, 7, 18, "R3 R5");         // 13..15,8..12
    run_burst(29, 3, 1'b0, 4, 24, "R5 R10");        // 29..31,16..28, no wait
    run_burst(21, 2, 1'b0, 0, 14, "R3 R5");         // latency code 0 acts as 2
    run_burst(14, 1, 1'b1, 3, 12, "R6 R8");         // 14,15,wait2,16,17
    run_burst(3, 3, 1'b1, 2, 26, "R6 R8");          // 3..15,wait3,16..18
    run_burst(61, 7, 1'b0, 2, 40, "R7 R8 R9");      // one wait at 64, none at 80/96
    run_burst(60, 7, 1'b1, 2, 30, "R7 R9");         // crosses bank at 64, no wait
    run_burst(0, 5, 1'b0, 2, 24, "R7");             // unused code runs on, no wrap
    run_burst(250, 7, 1'b1, 2, 14, "R4 R9");        // rolls past top of array
    run_burst(0, 7, 1'b1, 2, 5, "R12");
    run_burst(9, 1, 1'b0, 2, 10, "R12");            // restart: 9,10,11,8
    t_ce_drop_r11();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule